// File: doc/BRIEF.md
# Spectral Subtraction Noise Suppressor

This block cleans a stream of spectral magnitudes, one value per frequency bin, frame after frame. After reset it spends a fixed number of frames learning the background noise. For each bin position it sums the magnitudes it receives, and a right shift turns that sum into the average. It produces no output during this phase. Once the learning frames are done, the stored spectrum is frozen. From then on every incoming magnitude has the noise average for its bin subtracted from it. The result may not fall below a floor equal to half the noise average.

The input and output data paths use valid/ready handshakes. A sample moves in on a cycle where `in_valid` and `in_ready` are both high. Its result is registered and appears on `out_mag` with `out_valid` high on the next cycle. The value stays there unchanged until `out_ready` takes it. During learning the block accepts every sample (`in_ready` stays high), because learning produces nothing downstream can hold up. In the subtraction phase `in_ready` is low only while a result is held and `out_ready` is low.

`frame_start` is a plain one-cycle pulse that marks the start of a new frame. Bin positions come from the order of arrival: the first sample accepted after a pulse is bin 0, the next is bin 1, and so on.

Top module: `ssn_suppressor`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: While fewer than LEARN_FRAMES (8) `frame_start` pulses have been seen since reset, no output is produced (`out_valid` stays 0) and `in_ready` stays 1.
- R3: The bin index of an accepted sample is the number of samples accepted since the last `frame_start` pulse, modulo 2^ADDR_W. During learning, the first frame (before the first pulse) stores each sample in its bin. Each later learning frame adds its sample to the stored value.
- R4: After the 8th `frame_start` pulse, the stored sums no longer change and the frame count stops. Every later frame uses the same noise estimate.
- R5: The noise estimate of a bin is its stored sum shifted right by log2(LEARN_FRAMES) = 3. The output is computed as a signed value, `in_mag - est`. If that value is larger than `est >> 1` it is the output; otherwise the output is `est >> 1`, so a negative difference always gives the floor.
- R6: In the subtraction phase, a sample accepted at a clock edge has its result on `out_mag`, with `out_valid` high, after that same edge.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_mag` holds steady, `out_valid` stays 1 and `in_ready` is 0. Samples offered in this state are not taken.
- R8: A sample accepted in the same cycle as a `frame_start` pulse belongs to the new frame as bin 0. The pulse that completes learning also places such a sample in the subtraction phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| in_valid | input | 1 | Input magnitude is valid |
| in_ready | output | 1 | Block can take an input magnitude |
| in_mag | input | MAG_W (16) | Unsigned bin magnitude |
| out_valid | output | 1 | Enhanced magnitude is valid |
| out_ready | input | 1 | Downstream takes the enhanced magnitude |
| out_mag | output | MAG_W (16) | Unsigned enhanced magnitude |

## Verification
The hardest case to reach is the switch from learning to subtraction. Getting there takes eight full frames with known magnitudes in every bin. The first frame's store-instead-of-add rule and the truncating average must both match exactly, or every later result is off. The bench runs eight random learning frames and tracks per-bin sums in its own model. It then offers magnitudes chosen relative to each bin's estimate (zero, equal to the estimate, just past the floor, full scale) to test the floor comparison. It also sends a sample together with a frame pulse and holds the output stalled while a different sample waits at the input.

// File: rtl/ssn_pkg.sv
package ssn_pkg;

  // Operating phase of the suppressor.
  typedef enum logic [0:0] {
    PH_LEARN    = 1'b0,
    PH_SUBTRACT = 1'b1
  } ssn_phase_e;

  // Default geometry shared by the block and its bench.
  localparam int unsigned SSN_MAG_W        = 16;
  localparam int unsigned SSN_ADDR_W       = 8;
  localparam int unsigned SSN_LEARN_FRAMES = 8;

endpackage

// File: rtl/ssn_bin_counter.sv
module ssn_bin_counter #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              accept,
  output logic [ADDR_W-1:0] addr_now
);

  logic [ADDR_W-1:0] cnt_q;
  logic [ADDR_W-1:0] cnt_d;

  // A frame pulse places the sample of this cycle at bin 0.
  assign addr_now = frame_start ? '0 : cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (frame_start) begin
      cnt_d = accept ? ADDR_W'(1) : '0;
    end else if (accept) begin
      cnt_d = cnt_q + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R8: after a frame pulse the count restarts from the new frame's first bin.
  assert_bin_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (cnt_q == (($past(accept)) ? ADDR_W'(1) : ADDR_W'(0))));

endmodule

// File: rtl/ssn_frame_counter.sv
module ssn_frame_counter
  import ssn_pkg::*;
#(
  parameter int unsigned LEARN_FRAMES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_start,
  output ssn_phase_e phase_now,
  output ssn_phase_e phase_q,
  output logic       first_frame_now
);

  localparam int unsigned CNT_W = $clog2(LEARN_FRAMES + 1);

  logic [CNT_W-1:0] frm_q;
  logic [CNT_W-1:0] frm_now;
  logic             done_q;

  // Frame count as seen by a sample arriving in this cycle.
  assign frm_now         = (frame_start && !done_q) ? frm_q + CNT_W'(1) : frm_q;
  assign first_frame_now = (frm_now == '0);
  assign phase_q         = done_q ? PH_SUBTRACT : PH_LEARN;
  assign phase_now       = (done_q || (frm_now == CNT_W'(LEARN_FRAMES)))
                           ? PH_SUBTRACT : PH_LEARN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q && frame_start) begin
      frm_q  <= frm_now;
      done_q <= (frm_now == CNT_W'(LEARN_FRAMES));
    end
  end

  // R4: once learning ends the frame count never moves again.
  assert_frame_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> (done_q && $stable(frm_q)));

  // R2: learning ends only on a frame pulse.
  assert_learn_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_q && !frame_start) |=> !done_q);

endmodule

// File: rtl/ssn_noise_store.sv
module ssn_noise_store #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned SUM_W  = 19,
  parameter int unsigned MAG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              replace,
  input  logic [ADDR_W-1:0] addr,
  input  logic [MAG_W-1:0]  mag,
  output logic [SUM_W-1:0]  sum_rd
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [SUM_W-1:0] mem [DEPTH];
  logic [SUM_W-1:0] wr_val;

  // Read and write share one address: read-modify-write in a single cycle.
  assign sum_rd = mem[addr];
  assign wr_val = replace ? SUM_W'(mag) : (sum_rd + SUM_W'(mag));

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wr_val;
  end

  // R3: a first-frame write lands exactly the sample value.
  assert_first_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && replace) |=> (mem[$past(addr)] == SUM_W'($past(mag))));

endmodule

// File: rtl/ssn_subtract_floor.sv
module ssn_subtract_floor #(
  parameter int unsigned MAG_W       = 16,
  parameter int unsigned SUM_W       = 19,
  parameter int unsigned AVG_SHIFT   = 3,
  parameter int unsigned FLOOR_SHIFT = 1
) (
  input  logic [MAG_W-1:0] mag,
  input  logic [SUM_W-1:0] sum,
  output logic [MAG_W-1:0] result
);

  logic [MAG_W-1:0]      est;
  logic [MAG_W-1:0]      floor_v;
  logic signed [MAG_W:0] diff;
  logic signed [MAG_W:0] floor_s;

  // Average over the learning frames: a pure shift of the stored sum.
  assign est = MAG_W'(sum >> AVG_SHIFT);

  // Floor is a scaled copy of the estimate, taken by moving the binary point.
  generate
    if (FLOOR_SHIFT == 0) begin : g_floor_full
      assign floor_v = est;
    end else begin : g_floor_scaled
      assign floor_v = {{FLOOR_SHIFT{1'b0}}, est[MAG_W-1:FLOOR_SHIFT]};
    end
  endgenerate

  assign diff    = $signed({1'b0, mag}) - $signed({1'b0, est});
  assign floor_s = $signed({1'b0, floor_v});
  assign result  = (diff > floor_s) ? MAG_W'(diff) : floor_v;

endmodule

// File: rtl/ssn_suppressor.sv
module ssn_suppressor
  import ssn_pkg::*;
#(
  parameter int unsigned MAG_W        = SSN_MAG_W,
  parameter int unsigned ADDR_W       = SSN_ADDR_W,
  parameter int unsigned LEARN_FRAMES = SSN_LEARN_FRAMES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [MAG_W-1:0] in_mag,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [MAG_W-1:0] out_mag
);

  localparam int unsigned AVG_SHIFT = $clog2(LEARN_FRAMES);
  localparam int unsigned SUM_W     = MAG_W + AVG_SHIFT;

  ssn_phase_e        phase_now;
  ssn_phase_e        phase_q;
  logic              first_frame_now;
  logic              accept;
  logic              wr_en;
  logic [ADDR_W-1:0] addr_now;
  logic [SUM_W-1:0]  sum_rd;
  logic [MAG_W-1:0]  result;
  logic              out_valid_q;
  logic [MAG_W-1:0]  out_mag_q;

  assign in_ready = (phase_q == PH_LEARN) || !out_valid_q || out_ready;
  assign accept   = in_valid && in_ready;
  assign wr_en    = accept && (phase_now == PH_LEARN);

  ssn_bin_counter #(.ADDR_W(ADDR_W)) u_bins (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .accept      (accept),
    .addr_now    (addr_now)
  );

  ssn_frame_counter #(.LEARN_FRAMES(LEARN_FRAMES)) u_frames (
    .clk             (clk),
    .rst_n           (rst_n),
    .frame_start     (frame_start),
    .phase_now       (phase_now),
    .phase_q         (phase_q),
    .first_frame_now (first_frame_now)
  );

  ssn_noise_store #(.ADDR_W(ADDR_W), .SUM_W(SUM_W), .MAG_W(MAG_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .replace (first_frame_now),
    .addr    (addr_now),
    .mag     (in_mag),
    .sum_rd  (sum_rd)
  );

  ssn_subtract_floor #(
    .MAG_W(MAG_W), .SUM_W(SUM_W), .AVG_SHIFT(AVG_SHIFT), .FLOOR_SHIFT(1)
  ) u_sub (
    .mag    (in_mag),
    .sum    (sum_rd),
    .result (result)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_q <= 1'b0;
      out_mag_q   <= '0;
    end else if (accept && (phase_now == PH_SUBTRACT)) begin
      out_valid_q <= 1'b1;
      out_mag_q   <= result;
    end else if (out_ready) begin
      out_valid_q <= 1'b0;
    end
  end

  assign out_valid = out_valid_q;
  assign out_mag   = out_mag_q;

  // R2: nothing leaves the block while it is still learning.
  assert_quiet_learn_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_LEARN) |-> !out_valid_q);

  // R7: a stalled result is held unchanged.
  assert_hold_output_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_q && !out_ready) |=> (out_valid_q && $stable(out_mag_q)));

  // R4: the noise store is never written after learning.
  assert_store_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SUBTRACT) |-> !wr_en);

endmodule

// File: tb/ssn_suppressor_test.sv
module ssn_suppressor_test;

  localparam int MAG_W = 16;
  localparam int NB    = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             frame_start = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [MAG_W-1:0] in_mag = '0;
  logic             out_valid;
  logic             out_ready = 1'b1;
  logic [MAG_W-1:0] out_mag;

  int errors = 0;
  int checks = 0;
  int sums [256];
  int mframe = 0;
  int mbin = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ssn_suppressor uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .in_valid(in_valid), .in_ready(in_ready), .in_mag(in_mag),
    .out_valid(out_valid), .out_ready(out_ready), .out_mag(out_mag)
  );

  function automatic int expect_out(int b, int mag);
    int est, fl, d;
    est = sums[b] >>> 3;
    fl  = est >>> 1;
    d   = mag - est;
    return (d > fl) ? d : fl;
  endfunction

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // Model update for one accepted sample; returns its bin.
  task automatic model_take(int mag, output int b);
    b = mbin;
    if (mframe < 8) begin
      if (mframe == 0) sums[b] = mag;
      else             sums[b] = sums[b] + mag;
    end
    mbin = (mbin + 1) % 256;
  endtask

  // Send one sample with out_ready high and check the result.
  task automatic send(int mag, bit with_pulse);
    int b;
    @(negedge clk);
    in_valid = 1'b1;
    in_mag = MAG_W'(mag);
    frame_start = with_pulse;
    if (with_pulse) begin
      mbin = 0;
      if (mframe < 8) mframe++;
    end
    @(posedge clk);
    model_take(mag, b);
    @(negedge clk);
    in_valid = 1'b0;
    frame_start = 1'b0;
    if (mframe < 8) begin
      check("R2 no output while learning", int'(out_valid), 0);
      check("R2 input always ready while learning", int'(in_ready), 1);
    end else begin
      check("R6 output valid one cycle after accept", int'(out_valid), 1);
      check("R5 subtract and floor", int'(out_mag), expect_out(b, mag));
    end
  endtask

  task automatic pulse();
    @(negedge clk);
    frame_start = 1'b1;
    mbin = 0;
    if (mframe < 8) mframe++;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int a_mag, b_mag, held, b0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 out_valid after reset", int'(out_valid), 0);
    check("R1 in_ready after reset", int'(in_ready), 1);
    rst_n = 1'b1;

    // R3: eight learning frames; first stores, later ones add.
    for (int f = 0; f < 8; f++) begin
      if (f != 0) pulse();
      for (int i = 0; i < NB; i++) send(int'($urandom_range(0, 2047)), 1'b0);
    end
    pulse();

    // R4/R5: several subtraction frames with random and directed values.
    for (int f = 0; f < 3; f++) begin
      for (int i = 0; i < NB; i++) begin
        int e = sums[i] >>> 3;
        case (i % 4)
          0: send(0, 1'b0);                             // R5 negative -> floor
          1: send(e, 1'b0);                             // R5 zero diff -> floor
          2: send(e + (e >>> 1) + 1, 1'b0);             // R5 just above floor
          default: send(int'($urandom_range(0, 65535)), 1'b0);
        endcase
      end
      pulse();
    end
    // R4: random frames again with the frozen estimate.
    for (int f = 0; f < 2; f++) begin
      for (int i = 0; i < NB; i++) send(int'($urandom_range(0, 4095)), 1'b0);
      pulse();
    end
    send(65535, 1'b0);   // R5 full scale

    // R8: sample together with a frame pulse is bin 0; short frame restarts.
    send(3000, 1'b1);
    send(2500, 1'b0);
    send(1234, 1'b1);
    check("R8 counter restarted by pulse", mbin, 1);

    // R7: back-pressure.
    a_mag = 4000;
    b_mag = 100;
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1;
    in_mag = MAG_W'(a_mag);
    @(posedge clk);
    model_take(a_mag, b0);
    @(negedge clk);
    held = expect_out(b0, a_mag);
    in_mag = MAG_W'(b_mag);
    check("R7 stalled output valid", int'(out_valid), 1);
    check("R7 stalled output value", int'(out_mag), held);
    check("R7 in_ready low while stalled", int'(in_ready), 0);
    repeat (3) begin
      @(negedge clk);
      check("R7 output held", int'(out_mag), held);
      check("R7 input refused", int'(in_ready), 0);
    end
    out_ready = 1'b1;
    @(posedge clk);
    model_take(b_mag, b0);
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 waiting sample taken after release", int'(out_mag), expect_out(b0, b_mag));
    check("R3 bin advanced once per accepted sample", b0, 2);
    @(negedge clk);
    check("R7 output drains", int'(out_valid), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule